// File: doc/BRIEF.md
# Single-Page Bus-Mastering Word Mover

This block copies a programmed run of 32-bit words from a streaming device port into memory, and it does so by becoming bus master itself. Software sets a start address and a word count through a small register-write port, then writes the start bit. The engine checks that the whole run is word-aligned and stays inside one 4 KiB page. It then raises a bus request and touches nothing until the grant arrives. For each word it takes one value from the device, presents it to memory as a single-beat write at the current address, and adds 4 to the address once the write is accepted.

When the count runs out the engine drops its request and sets a done flag. It stops early and sets an error flag on any of three causes: a memory error response, a misaligned start address, or a run that would cross a page. Both flags drive one level interrupt, and a write to the status register clears them. A start that is rejected never requests the bus, and a zero-length start finishes at once without using the bus.

Top module: `dma_engine`

## Requirements
- R1: A start that passes the page check raises `bus_req_o` in the cycle after the start write. `mem_wr_o` stays low until `bus_gnt_i` has been seen high while requesting.
- R2: For each word, the engine pulses `dev_pop_o` in a cycle where `dev_valid_i` is high and takes that `dev_data_i`. It then holds `mem_wr_o` with unchanged address and data until `mem_ready_i` is high. Words reach memory in device order.
- R3: The first write goes to the start address. Each later write goes to the previous address plus 4. Exactly the programmed count of writes is issued, and all of them stay in the start address's 4 KiB page.
- R4: In the cycle after the last write is accepted, `bus_req_o` is low, `busy_o` is low and `done_o` is high.
- R5: `irq_o` equals `done_o | err_o`. It rises only after completion or an error. Any write with `cfg_sel`=3 clears both flags. A flag being set in the same cycle as a clear write wins over the clear.
- R6: Registers are selected by `cfg_sel`: 0 is the start address, 1 is the word count (low 11 bits), 2 is control (bit 0 = start), 3 is status clear. While `busy_o` is high, writes to selects 0, 1 and 2 are ignored.
- R7: A start is rejected if the address is not a multiple of 4, or if the page offset plus 4 times the count exceeds 4096. A rejected start sets `err_o` and never raises `bus_req_o`. A count of 0 sets `done_o` without a request.
- R8: A memory write accepted with `mem_err_i` high ends the run. `err_o` is set, `bus_req_o` drops in the next cycle and no further write is issued.
- R9: After reset, `bus_req_o`, `mem_wr_o`, `dev_pop_o`, `busy_o`, `done_o`, `err_o` and `irq_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| mem_wr_o | output | 1 | Memory write beat valid |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the beat |
| mem_err_i | input | 1 | Error response, valid with ready |
| dev_valid_i | input | 1 | Device word available |
| dev_data_i | input | 32 | Device word |
| dev_pop_o | output | 1 | Device word consumed this cycle |
| irq_o | output | 1 | Interrupt, level |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Completion flag |
| err_o | output | 1 | Error flag |

## Verification
The interesting collision is between software clearing the status and the engine setting the done flag on the final beat. The bench provokes it by driving the clear write in exactly the cycle where the last write handshake completes. It judges the result by requiring `done_o` and `irq_o` to still be high when the run ends. A second overlap is software writing a new address and a new start while a run is in progress. The bench checks that every address issued afterwards still follows the original start address.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_FETCH = 2'd2,
    ST_WRITE = 2'd3
  } dma_state_e;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
  localparam logic [1:0] SEL_STAT  = 2'd3;

  // True when a run of 'words' beats of 2**shift bytes starting at 'addr'
  // ends at or before the end of the page holding 'addr'.
  function automatic logic page_fits(input logic [63:0] addr,
                                     input logic [63:0] words,
                                     input int unsigned page_bits,
                                     input int unsigned shift);
    logic [63:0] mask;
    logic [63:0] span;
    mask = (64'd1 << page_bits) - 64'd1;
    span = (addr & mask) + (words << shift);
    return span <= (64'd1 << page_bits);
  endfunction

  // Address of the beat that follows 'addr'.
  function automatic logic [63:0] step_addr(input logic [63:0] addr,
                                            input int unsigned shift);
    return addr + (64'd1 << shift);
  endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CNT_W     = 11,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned SHIFT     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              busy,
  output logic [ADDR_W-1:0] base_addr,
  output logic [CNT_W-1:0]  word_cnt,
  output logic              start_go,
  output logic              start_reject,
  output logic              start_empty,
  output logic              stat_clr
);

  logic start_hit;
  logic misaligned;
  logic fits;
  logic bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      word_cnt  <= '0;
    end else if (cfg_we && !busy) begin
      if (cfg_sel == SEL_ADDR)  base_addr <= cfg_wdata;
      if (cfg_sel == SEL_COUNT) word_cnt  <= cfg_wdata[CNT_W-1:0];
    end
  end

  generate
    if (SHIFT > 0) begin : g_align
      assign misaligned = |base_addr[SHIFT-1:0];
    end else begin : g_noalign
      assign misaligned = 1'b0;
    end
  endgenerate

  assign fits      = page_fits(64'(base_addr), 64'(word_cnt), PAGE_BITS, SHIFT);
  assign bad       = misaligned || !fits;
  assign start_hit = cfg_we && (cfg_sel == SEL_CTRL) && cfg_wdata[0] && !busy;

  assign start_reject = start_hit && bad;
  assign start_empty  = start_hit && !bad && (word_cnt == '0);
  assign start_go     = start_hit && !bad && (word_cnt != '0);
  assign stat_clr     = cfg_we && (cfg_sel == SEL_STAT);

endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 11,
  parameter int unsigned SHIFT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_go,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  word_cnt,
  input  logic              bus_gnt,
  input  logic              dev_valid,
  input  logic [DATA_W-1:0] dev_data,
  input  logic              mem_ready,
  input  logic              mem_err,
  output logic              bus_req,
  output logic              dev_pop,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              beat_ok,
  output logic              last_beat,
  output logic              xfer_done,
  output logic              xfer_abort
);

  dma_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [DATA_W-1:0] data_q;
  logic              beat_fire;

  assign beat_fire  = (state_q == ST_WRITE) && mem_ready;
  assign beat_ok    = beat_fire && !mem_err;
  assign xfer_abort = beat_fire && mem_err;
  assign last_beat  = (left_q == CNT_W'(1));
  assign xfer_done  = beat_ok && last_beat;

  assign bus_req   = (state_q != ST_IDLE);
  assign busy      = bus_req;
  assign dev_pop   = (state_q == ST_FETCH) && dev_valid;
  assign mem_wr    = (state_q == ST_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_go) begin
            addr_q  <= base_addr;
            left_q  <= word_cnt;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (bus_gnt) state_q <= ST_FETCH;
        end
        ST_FETCH: begin
          if (dev_valid) begin
            data_q  <= dev_data;
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (xfer_abort) begin
            state_q <= ST_IDLE;
          end else if (beat_ok) begin
            addr_q  <= ADDR_W'(step_addr(64'(addr_q), SHIFT));
            left_q  <= left_q - CNT_W'(1);
            state_q <= last_beat ? ST_IDLE : ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_status.sv
module dma_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_done,
  input  logic set_err,
  input  logic clr,
  output logic done,
  output logic err,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (set_done)  done <= 1'b1;
      else if (clr)  done <= 1'b0;
      if (set_err)   err  <= 1'b1;
      else if (clr)  err  <= 1'b0;
    end
  end

  assign irq = done | err;

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 11,
  parameter int unsigned PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic              mem_err_i,
  input  logic              dev_valid_i,
  input  logic [DATA_W-1:0] dev_data_i,
  output logic              dev_pop_o,
  output logic              irq_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int unsigned SHIFT = $clog2(DATA_W / 8);

  logic [ADDR_W-1:0] base_addr;
  logic [CNT_W-1:0]  word_cnt;
  logic              start_go;
  logic              start_reject;
  logic              start_empty;
  logic              stat_clr;
  logic              beat_ok;
  logic              last_beat;
  logic              xfer_done;
  logic              xfer_abort;
  logic              xfer_stop;
  logic              end_evt;

  dma_cfg_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_BITS(PAGE_BITS), .SHIFT(SHIFT)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy_o), .base_addr(base_addr),
    .word_cnt(word_cnt), .start_go(start_go), .start_reject(start_reject),
    .start_empty(start_empty), .stat_clr(stat_clr)
  );

  dma_mover #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .SHIFT(SHIFT)
  ) u_mover (
    .clk(clk), .rst_n(rst_n), .start_go(start_go), .base_addr(base_addr),
    .word_cnt(word_cnt), .bus_gnt(bus_gnt_i), .dev_valid(dev_valid_i),
    .dev_data(dev_data_i), .mem_ready(mem_ready_i), .mem_err(mem_err_i),
    .bus_req(bus_req_o), .dev_pop(dev_pop_o), .mem_wr(mem_wr_o),
    .mem_addr(mem_addr_o), .mem_wdata(mem_wdata_o), .busy(busy_o),
    .beat_ok(beat_ok), .last_beat(last_beat), .xfer_done(xfer_done),
    .xfer_abort(xfer_abort)
  );

  dma_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .set_done(xfer_done | start_empty),
    .set_err(xfer_abort | start_reject),
    .clr(stat_clr), .done(done_o), .err(err_o), .irq(irq_o)
  );

  assign xfer_stop = xfer_done | xfer_abort;
  assign end_evt   = xfer_stop | start_reject | start_empty;

endmodule

// File: rtl/dma_engine_sva.sv
module dma_engine_sva #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned SHIFT     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req_o,
  input logic              mem_wr_o,
  input logic              mem_ready_i,
  input logic              mem_err_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              irq_o,
  input logic [ADDR_W-1:0] base_addr,
  input logic              beat_ok,
  input logic              last_beat,
  input logic              xfer_stop,
  input logic              start_reject,
  input logic              end_evt
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << SHIFT);

  AST_WR_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> bus_req_o); // R1

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_o && !mem_ready_i) |=>
      (mem_wr_o && $stable(mem_addr_o) && $stable(mem_wdata_o))); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ok && !last_beat) |=> (mem_addr_o == $past(mem_addr_o) + STEP)); // R3

  AST_PAGE_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> (mem_addr_o[ADDR_W-1:PAGE_BITS] == base_addr[ADDR_W-1:PAGE_BITS])); // R3

  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stop |=> !bus_req_o); // R4

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(end_evt)); // R5

  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |=> !bus_req_o); // R7

  AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_o && mem_ready_i && mem_err_i) |=> !mem_wr_o); // R8

endmodule

bind dma_engine dma_engine_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS), .SHIFT(SHIFT)
) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_req_o(bus_req_o), .mem_wr_o(mem_wr_o),
  .mem_ready_i(mem_ready_i), .mem_err_i(mem_err_i), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .irq_o(irq_o), .base_addr(base_addr),
  .beat_ok(beat_ok), .last_beat(last_beat), .xfer_stop(xfer_stop),
  .start_reject(start_reject), .end_evt(end_evt)
);

// File: tb/sim_dma_engine.sv
module sim_dma_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        bus_req_o;
  logic        bus_gnt_i = 1'b0;
  logic        mem_wr_o;
  logic [31:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic        mem_ready_i = 1'b0;
  logic        mem_err_i = 1'b0;
  logic        dev_valid_i = 1'b0;
  logic [31:0] dev_data_i = '0;
  logic        dev_pop_o;
  logic        irq_o;
  logic        busy_o;
  logic        done_o;
  logic        err_o;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dma_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i),
    .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready_i), .mem_err_i(mem_err_i), .dev_valid_i(dev_valid_i),
    .dev_data_i(dev_data_i), .dev_pop_o(dev_pop_o), .irq_o(irq_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [10:0] cnt;
    logic [3:0]  gdly;
    logic        gaps;
    logic [10:0] err_at;
    logic        poke;
    logic        clr_end;
    logic        exp_done;
    logic        exp_err;
    logic [10:0] exp_beats;
  } vec_t;

  localparam int NV = 9;
  localparam logic [10:0] NONE = 11'h7FF;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 11'd4,    4'd0, 1'b0, NONE,  1'b0, 1'b1, 1'b1, 1'b0, 11'd4},
    '{32'h0000_2FF0, 11'd4,    4'd2, 1'b0, NONE,  1'b0, 1'b0, 1'b1, 1'b0, 11'd4},
    '{32'h0000_2FF4, 11'd4,    4'd0, 1'b0, NONE,  1'b0, 1'b0, 1'b0, 1'b1, 11'd0},
    '{32'h0000_0002, 11'd1,    4'd0, 1'b0, NONE,  1'b0, 1'b0, 1'b0, 1'b1, 11'd0},
    '{32'h0000_4000, 11'd0,    4'd0, 1'b0, NONE,  1'b0, 1'b0, 1'b1, 1'b0, 11'd0},
    '{32'h0000_5000, 11'd8,    4'd5, 1'b1, NONE,  1'b1, 1'b0, 1'b1, 1'b0, 11'd8},
    '{32'h0000_6000, 11'd6,    4'd1, 1'b1, 11'd2, 1'b0, 1'b0, 1'b0, 1'b1, 11'd3},
    '{32'h0000_7000, 11'd1024, 4'd0, 1'b0, NONE,  1'b0, 1'b0, 1'b1, 1'b0, 11'd1024},
    '{32'h0000_7004, 11'd1024, 4'd0, 1'b0, NONE,  1'b0, 1'b0, 1'b0, 1'b1, 11'd0}
  };

  function automatic logic [31:0] pat(input int vi, input int k);
    return 32'hA500_0000 ^ (32'(vi) << 16) ^ 32'(k);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic run_vec(input int vi);
    vec_t v;
    int beats, pops, viol, early, bad_a, bad_d, cyc;
    bit req_first, ended;
    v = VECS[vi];
    beats = 0; pops = 0; viol = 0; early = 0; bad_a = 0; bad_d = 0;
    req_first = 1'b0; ended = 1'b0;
    bus_gnt_i = 0; mem_ready_i = 0; mem_err_i = 0; dev_valid_i = 0;
    cfg_write(2'd0, v.addr);
    cfg_write(2'd1, 32'(v.cnt));
    cfg_write(2'd2, 32'd1);
    for (int c = 0; c < 4000; c++) begin
      cyc = c;
      @(negedge clk);
      cfg_we = 1'b0;
      if (c == 0) req_first = bus_req_o;
      if (!busy_o) begin ended = 1'b1; break; end
      if (mem_wr_o && !bus_gnt_i) viol++;
      if (irq_o) early++;
      bus_gnt_i   = bus_req_o && (c >= int'(v.gdly));
      dev_valid_i = v.gaps ? (c % 3 != 1) : 1'b1;
      dev_data_i  = pat(vi, pops);
      mem_ready_i = v.gaps ? (c % 2 == 0) : 1'b1;
      mem_err_i   = mem_ready_i && (beats == int'(v.err_at));
      if (v.poke && c == 4) begin cfg_we = 1; cfg_sel = 2'd0; cfg_wdata = 32'h0000_9000; end
      if (v.poke && c == 6) begin cfg_we = 1; cfg_sel = 2'd2; cfg_wdata = 32'd1; end
      #1;
      if (dev_pop_o) pops++;
      if (mem_wr_o && mem_ready_i) begin
        if (mem_addr_o != v.addr + 32'(beats * 4)) bad_a++;
        if (mem_wdata_o != pat(vi, beats)) bad_d++;
        if (v.clr_end && beats == int'(v.cnt) - 1) begin
          cfg_we = 1; cfg_sel = 2'd3; cfg_wdata = 32'd0;
        end
        beats++;
      end
    end
    chk(ended, "R4", $sformatf("v%0d run ended", vi), 32'(cyc), 32'd0);
    if (v.exp_beats != 0)
      chk(req_first == 1'b1, "R1", $sformatf("v%0d req after start", vi), 32'(req_first), 32'd1);
    else
      chk(req_first == 1'b0, "R7", $sformatf("v%0d no req", vi), 32'(req_first), 32'd0);
    chk(viol == 0, "R1", $sformatf("v%0d write before grant", vi), 32'(viol), 32'd0);
    chk(pops == beats, "R2", $sformatf("v%0d pops vs beats", vi), 32'(pops), 32'(beats));
    chk(bad_d == 0, "R2", $sformatf("v%0d data order", vi), 32'(bad_d), 32'd0);
    chk(bad_a == 0, (v.poke ? "R6" : "R3"), $sformatf("v%0d addresses", vi), 32'(bad_a), 32'd0);
    chk(beats == int'(v.exp_beats), (v.exp_err ? "R8" : "R3"),
        $sformatf("v%0d beat count", vi), 32'(beats), 32'(v.exp_beats));
    chk(done_o == v.exp_done, (v.clr_end ? "R5" : "R4"),
        $sformatf("v%0d done", vi), 32'(done_o), 32'(v.exp_done));
    chk(err_o == v.exp_err, (v.exp_beats == 0 ? "R7" : "R8"),
        $sformatf("v%0d err", vi), 32'(err_o), 32'(v.exp_err));
    chk(irq_o == (v.exp_done | v.exp_err), "R5", $sformatf("v%0d irq", vi),
        32'(irq_o), 32'(v.exp_done | v.exp_err));
    chk(early == 0, "R5", $sformatf("v%0d irq during run", vi), 32'(early), 32'd0);
    chk(bus_req_o == 1'b0, "R4", $sformatf("v%0d req released", vi), 32'(bus_req_o), 32'd0);
    bus_gnt_i = 0; mem_ready_i = 0; mem_err_i = 0; dev_valid_i = 0;
    cfg_write(2'd3, 32'd0);
    chk(irq_o == 1'b0 && done_o == 1'b0 && err_o == 1'b0, "R5",
        $sformatf("v%0d status clear", vi), {29'd0, irq_o, done_o, err_o}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk(!bus_req_o && !mem_wr_o && !dev_pop_o && !busy_o, "R9", "bus side idle",
        {28'd0, bus_req_o, mem_wr_o, dev_pop_o, busy_o}, 32'd0);
    chk(!done_o && !err_o && !irq_o, "R9", "flags clear",
        {29'd0, done_o, err_o, irq_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!bus_req_o && !irq_o, "R9", "idle after release",
        {30'd0, bus_req_o, irq_o}, 32'd0);
    for (int i = 0; i < NV; i++) run_vec(i);
    // R6: count write while idle then reject shows the register took it
    cfg_write(2'd0, 32'h0000_3000);
    cfg_write(2'd1, 32'd1025);
    cfg_write(2'd2, 32'd1);
    @(negedge clk);
    chk(err_o == 1'b1 && bus_req_o == 1'b0, "R6", "oversize count rejected",
        {30'd0, err_o, bus_req_o}, 32'd2);
    cfg_write(2'd3, 32'd0);
    // R6: control write with bit0 low does not start
    cfg_write(2'd1, 32'd2);
    cfg_write(2'd2, 32'd0);
    @(negedge clk);
    chk(bus_req_o == 1'b0 && busy_o == 1'b0, "R6", "start bit low ignored",
        {30'd0, bus_req_o, busy_o}, 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule